// File: doc/BRIEF.md
# SDRAM Periodic Refresh Scheduler

This block keeps one or more SDRAM chip selects refreshed without help from software. A free-running interval timer raises a refresh request at a fixed period. The request is held until the memory access arbiter grants it. After the grant, the block drives a refresh event onto the command strobes. By default that event is four auto-refresh commands. Each command is followed by idle NOP clocks, so that back-to-back refreshes on the same device respect the refresh cycle time. The device's internal row counter picks the row, so no address is driven.

When several chip selects share one scheduler, each timer period serves only one of them. The served chip select rotates after every completed event. The timer period therefore has to shrink in proportion to the number of chip selects, so that each device still sees the same refresh interval. A parameter selects between a four-command event and a single-command event.

Top module: `sdram_refresh_sched`

## Requirements
- R1: While reset is asserted and right after it, `ref_req` and `ref_busy` are low and every strobe (`cs_n`, `ras_n`, `cas_n`, `we_n`) is high.
- R2: The timer fires on the INTERVAL-th rising clock edge after reset release and every INTERVAL edges after that. `ref_req` is high in the cycle that follows a firing, unless an event is in progress.
- R3: Once raised, `ref_req` stays high for any number of cycles until a grant is sampled. A refresh is never dropped.
- R4: A rising edge that sees `ref_gnt` and `ref_req` both high starts an event. From the next cycle `ref_busy` is high, `ref_req` is low, and a REF command is on the bus: the selected `cs_n` bit, `ras_n` and `cas_n` are low, and `we_n` is high.
- R5: An event lasts REFS × REF_GAP cycles. A REF is driven in the first cycle of each REF_GAP-cycle slot. The other cycles carry NOP to the same chip select (its `cs_n` bit low, `ras_n`, `cas_n` and `we_n` high). Outside an event all strobes are high.
- R6: With BURST4 = 1 an event holds REFS = 4 REF commands. With BURST4 = 0 it holds a single REF and lasts REF_GAP cycles.
- R7: Chip selects are served in the order 0, 1, …, NUM_CS−1, 0, … The pointer moves by one at the end of each event.
- R8: At most one `cs_n` bit is low in any cycle. Bit i belongs to chip select i.
- R9: A grant given while `ref_req` is low is ignored: `ref_busy` stays low and no strobe moves.
- R10: A timer firing during an event, or in the cycle its grant is taken, is kept. `ref_req` is high in the cycle after the event ends. Several firings before a grant merge into one event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt | input | 1 | Grant from the access arbiter, sampled while `ref_req` is high |
| ref_req | output | 1 | Refresh request to the arbiter |
| ref_busy | output | 1 | High while a refresh event owns the command bus |
| cs_n | output | NUM_CS | Active-low chip selects, bit i for chip select i |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low (held high by this block) |

## Verification
The first request is due in the cycle after the INTERVAL-th edge following reset release. A grant sampled at edge g puts the first REF on the bus right after g, the next REFs REF_GAP cycles apart, and drops `ref_busy` right after edge g + REFS×REF_GAP. The bench counts rising edges itself and samples every output on the falling edge, so each check lands in exactly the cycle where the result is due. Whether `ref_req` must be high after an event is worked out from that edge count: the bench checks whether any multiple of INTERVAL falls in the edge window from g to the end of the event. One grant is deliberately placed so that a timer firing lands inside an event, which exercises that case.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  localparam int REFS_BURST = 4;

  // REF commands issued for one refresh event
  function automatic int refs_per_event(bit burst4);
    return burst4 ? REFS_BURST : 1;
  endfunction

  // cycles one event keeps the bus
  function automatic int event_cycles(bit burst4, int gap);
    return refs_per_event(burst4) * gap;
  endfunction

  // next chip select in rotation
  function automatic int next_cs(int cur, int n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/rfs_timer.sv
module rfs_timer #(
  parameter int INTERVAL = 1560
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int TW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

  logic [TW-1:0] cnt;

  assign tick = (cnt == TW'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rfs_burst.sv
module rfs_burst #(
  parameter int REFS    = 4,
  parameter int REF_GAP = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active,
  output logic ref_slot,
  output logic done
);
  localparam int GW = (REF_GAP > 1) ? $clog2(REF_GAP) : 1;
  localparam int RW = (REFS > 1) ? $clog2(REFS) : 1;

  logic [GW-1:0] gap_cnt;
  logic [RW-1:0] ref_cnt;
  logic          gap_end, last_ref;

  assign gap_end  = (gap_cnt == GW'(REF_GAP - 1));
  assign last_ref = (ref_cnt == RW'(REFS - 1));
  assign ref_slot = active && (gap_cnt == '0);
  assign done     = active && gap_end && last_ref;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      gap_cnt <= '0;
      ref_cnt <= '0;
    end else if (start) begin
      active  <= 1'b1;
      gap_cnt <= '0;
      ref_cnt <= '0;
    end else if (active) begin
      if (gap_end) begin
        gap_cnt <= '0;
        if (last_ref) begin
          active  <= 1'b0;
          ref_cnt <= '0;
        end else begin
          ref_cnt <= ref_cnt + 1'b1;
        end
      end else begin
        gap_cnt <= gap_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rfs_rotor.sv
module rfs_rotor #(
  parameter int NUM_CS = 2,
  parameter int PW     = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  output logic [PW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n)       ptr <= '0;
    else if (advance) ptr <= PW'(rfs_pkg::next_cs(int'(ptr), NUM_CS));
  end
endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched #(
  parameter int NUM_CS   = 2,
  parameter int INTERVAL = 1560,
  parameter int REF_GAP  = 5,
  parameter bit BURST4   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_gnt,
  output logic              ref_req,
  output logic              ref_busy,
  output logic [NUM_CS-1:0] cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n
);
  localparam int REFS = rfs_pkg::refs_per_event(BURST4);
  localparam int PW   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

  // named internal events
  logic          tick;
  logic          burst_start;
  logic          burst_done;
  logic          ref_slot;
  logic          active;
  logic          pending;
  logic [PW-1:0] ptr;

  rfs_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  rfs_burst #(.REFS(REFS), .REF_GAP(REF_GAP)) u_burst (
    .clk(clk), .rst_n(rst_n), .start(burst_start),
    .active(active), .ref_slot(ref_slot), .done(burst_done)
  );

  rfs_rotor #(.NUM_CS(NUM_CS), .PW(PW)) u_rotor (
    .clk(clk), .rst_n(rst_n), .advance(burst_done), .ptr(ptr)
  );

  assign ref_req     = pending && !active;
  assign burst_start = ref_req && ref_gnt;

  // a new firing wins over the clear of the grant cycle
  always_ff @(posedge clk) begin
    if (!rst_n)           pending <= 1'b0;
    else if (tick)        pending <= 1'b1;
    else if (burst_start) pending <= 1'b0;
  end

  assign ref_busy = active;
  assign ras_n    = !ref_slot;
  assign cas_n    = !ref_slot;
  assign we_n     = 1'b1;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_n[i] = !(active && (ptr == PW'(i)));
  end
endmodule

// File: rtl/sdram_refresh_sched_chk.sv
module sdram_refresh_sched_chk #(
  parameter int NUM_CS = 2,
  parameter int PW     = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ref_gnt,
  input logic              ref_req,
  input logic              ref_busy,
  input logic [NUM_CS-1:0] cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [PW-1:0]     ptr,
  input logic              burst_done,
  input logic              tick
);
  // R3
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_gnt) |=> ref_req);

  // R4
  grant_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_gnt) |=> (ref_busy && !ras_n && !cas_n && we_n &&
                              ($countones(cs_n) == NUM_CS - 1)));

  // R4
  req_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_busy |-> !ref_req);

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_busy |-> ((&cs_n) && ras_n && cas_n && we_n));

  // R5
  ref_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |=> ras_n);

  // R7
  rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> (int'(ptr) == (int'($past(ptr)) + 1) % NUM_CS));

  // R8
  one_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1);

  // R9
  stray_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_gnt && !ref_req && !ref_busy) |=> !ref_busy);

  // R10
  tick_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (ref_req || ref_busy));
endmodule

bind sdram_refresh_sched sdram_refresh_sched_chk #(.NUM_CS(NUM_CS), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
  .ref_busy(ref_busy), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .ptr(ptr), .burst_done(burst_done), .tick(tick)
);

// File: tb/sdram_refresh_sched_test.sv
module sdram_refresh_sched_test;
  localparam int CS  = 3;
  localparam int IV  = 40;
  localparam int GAP = 5;
  localparam int B4  = 4 * GAP;
  localparam int B1  = GAP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gnt = 1'b0, gnt1 = 1'b0;
  logic req, busy, ras_n, cas_n, we_n;
  logic [CS-1:0] cs_n;
  logic req1, busy1, ras1_n, cas1_n, we1_n;
  logic [1:0] cs1_n;

  int total = 0, bad = 0, edges = 0;
  bit finished = 0;

  always #5 clk = ~clk;
  always @(posedge clk) if (rst_n) edges <= edges + 1;

  sdram_refresh_sched #(.NUM_CS(CS), .INTERVAL(IV), .REF_GAP(GAP), .BURST4(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .ref_gnt(gnt), .ref_req(req), .ref_busy(busy),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n));

  sdram_refresh_sched #(.NUM_CS(2), .INTERVAL(IV), .REF_GAP(GAP), .BURST4(1'b0)) uut_one (
    .clk(clk), .rst_n(rst_n), .ref_gnt(gnt1), .ref_req(req1), .ref_busy(busy1),
    .cs_n(cs1_n), .ras_n(ras1_n), .cas_n(cas1_n), .we_n(we1_n));

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at edge %0d", tag, act, exp, edges);
    end
  endtask

  // a firing lands on every edge that is a multiple of IV
  function automatic int tick_in(int from_e, int to_e);
    return ((to_e / IV) - ((from_e - 1) / IV)) > 0;
  endfunction

  task automatic t_reset;  // R1
    repeat (3) @(negedge clk);
    check("R1 reset strobes", {cs_n, ras_n, cas_n, we_n}, {CS+3{1'b1}});
    check("R1 reset req/busy", {req, busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {req, busy, cs_n, ras_n, cas_n, we_n}, {2'b00, {CS+3{1'b1}}});
  endtask

  task automatic t_stray;  // R9
    gnt = 1'b1;
    @(negedge clk);
    gnt = 1'b0;
    check("R9 stray grant busy", busy, 0);
    check("R9 stray grant strobes", {cs_n, ras_n, cas_n, we_n}, {CS+3{1'b1}});
  endtask

  task automatic t_first_req;  // R2
    while (edges < IV - 1) @(negedge clk);
    check("R2 no req before interval", req, 0);
    @(negedge clk);
    check("R2 req at interval", req, 1);
  endtask

  task automatic t_hold;  // R3
    while (edges % IV != 30) begin
      @(negedge clk);
      check("R3 req held without grant", req, 1);
    end
  endtask

  task automatic wait_req;
    while (!req) @(negedge clk);
  endtask

  task automatic t_event(int cs);  // R4 R5 R6 R7 R8 R10
    int g;
    check("R3 req before grant", req, 1);
    gnt = 1'b1;
    @(negedge clk);
    gnt = 1'b0;
    g = edges;
    for (int k = 0; k < B4; k++) begin
      logic [CS-1:0] ecs;
      logic re;
      ecs = ~(CS'(1) << cs);
      re  = (k % GAP == 0) ? 1'b0 : 1'b1;
      check("R4 busy/req during event", {busy, req}, 2'b10);
      check("R5 R7 R8 command", {cs_n, ras_n, cas_n, we_n}, {ecs, re, re, 1'b1});
      @(negedge clk);
    end
    check("R6 event length", busy, 0);
    check("R10 req after event", req, tick_in(g, edges));
  endtask

  task automatic t_single(int cs);  // R6
    int g;
    while (!req1) @(negedge clk);
    gnt1 = 1'b1;
    @(negedge clk);
    gnt1 = 1'b0;
    g = edges;
    for (int k = 0; k < B1; k++) begin
      logic [1:0] ecs;
      logic re;
      ecs = ~(2'(1) << cs);
      re  = (k == 0) ? 1'b0 : 1'b1;
      check("R6 single busy", busy1, 1);
      check("R6 single command", {cs1_n, ras1_n, cas1_n, we1_n}, {ecs, re, re, 1'b1});
      @(negedge clk);
    end
    check("R6 single length", busy1, 0);
    check("R10 single req after", req1, tick_in(g, edges));
  endtask

  initial begin
    t_reset();
    t_stray();
    t_first_req();
    t_hold();
    t_event(0);        // firing at a multiple of IV falls inside
    t_event(1);        // pending from that firing, then none
    wait_req();
    t_event(2);
    wait_req();
    t_event(0);        // R7 wraps
    t_single(0);
    t_single(1);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule